// File: doc/BRIEF.md
# Smart Card Interface Supervisor

This block is the digital control core that sits between a host processor and a smart card socket. It filters the socket's card-detect switch, watches the host's active-low power command, and decides which supply voltage the card gets. A plain level on the voltage-select line picks 5 V or 3 V. If that line drops within a short window on either side of the power command's falling edge, the block picks 1.8 V instead. Once the card is powered, the block produces a card clock enable strobe at a selectable fraction of the reference clock. It also drives an active-low interrupt toward the host.

The host starts a session by pulling the power command low while a filtered card is present. After a decision window of `WIN_CYCLES` reference cycles, the supply enable rises and the voltage code is latched. The session ends when the host releases the command or when the card is pulled out; removal takes effect without waiting for any filtering. The supply regulator, analog sensing of the divider pin and pad circuitry are outside the block. The divider choice arrives as a 2-bit code that is assumed quasi-static. The card-detect, command, voltage-select and fault inputs are resynchronised to the reference clock through `SYNC_STAGES` flops each. Because all four share the same delay, the relative timing between them is kept.

Top module: `sc_supervisor`

## Requirements
- R1: A card is accepted as present only after `card_det` has stayed high for `DEB_CYCLES` consecutive synchronised cycles. A shorter high pulse leaves the block as if no card had been inserted.
- R2: When `card_det` goes low, presence is cancelled at once, with no filtering. `supply_en` and `card_clk_en` are low three reference cycles after the pin falls.
- R3: A session starts only on a falling edge of `pwr_cmd_n` while a card is present, and only if the card stays present through the decision window. A command issued with no card leaves `supply_en` low.
- R4: `vsel_code` reads 2'b00 whenever `supply_en` is low. It reads 2'b10 (5 V) when `vsel` was high at the command edge and 2'b01 (3 V) when `vsel` was low, unless R5 or R6 applies.
- R5: If `vsel` fell d cycles before the command edge, with 0 <= d <= `WIN_CYCLES`, the code is 2'b11 (1.8 V). A fall from `WIN_CYCLES`+1 or more cycles earlier yields 3 V.
- R6: If `vsel` was high at the command edge and falls d cycles after it, with 1 <= d <= `WIN_CYCLES`, the code is 2'b11. A later fall keeps 5 V. `supply_en` rises only once this window has closed.
- R7: Changes on `vsel` while `supply_en` is high do not alter `vsel_code`.
- R8: While `supply_en` is high, `card_clk_en` is high for one reference cycle in every N. The divider code maps as 2'b00 -> N=4, 2'b01 -> N=1, 2'b10 -> N=8, 2'b11 -> N=2. The strobe is low whenever `supply_en` is low.
- R9: `div_sel` is sampled only while the card is not powered. A change during a session has no effect until the next session.
- R10: Any change of the filtered presence state (insertion accepted or removal) drives `irq_n` low. It stays low until the next edge, in either direction, of the synchronised power command.
- R11: `irq_n` is low for as long as the synchronised `fault` input is high.
- R12: Releasing `pwr_cmd_n` (driving it high) ends the session. `supply_en` and `card_clk_en` are low three reference cycles after the pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_det | input | 1 | Socket card-detect switch, high when a card is in |
| pwr_cmd_n | input | 1 | Host power command, active low |
| vsel | input | 1 | Host voltage-select line |
| div_sel | input | 2 | Card clock divider code |
| fault | input | 1 | Fault indication from the supply and pad circuitry |
| supply_en | output | 1 | Enables the card supply regulator |
| vsel_code | output | 2 | Selected card voltage: 00 off, 01 3 V, 10 5 V, 11 1.8 V |
| card_clk_en | output | 1 | One-cycle strobe that paces the card clock |
| irq_n | output | 1 | Active-low host interrupt |

## Verification
The hardest case to reach is the exact edge of the 1.8 V window. The voltage-select fall must land exactly `WIN_CYCLES` or `WIN_CYCLES`+1 cycles from the command edge, both before and after it. A wrong off-by-one in either direction only shows up there. The stimulus drives both pins on the same falling clock edge, and both pass through identical synchronisers, so the distance seen inside equals the distance driven. Each boundary case is placed at both window limits, along with a coincident fall. The card-removal path is entered in the middle of a powered session, which is also the only point where the immediate, unfiltered deactivation can be observed.

// File: rtl/sc_sup_pkg.sv
package sc_sup_pkg;

  typedef enum logic [1:0] {
    VC_OFF = 2'b00,
    VC_3V0 = 2'b01,
    VC_5V0 = 2'b10,
    VC_1V8 = 2'b11
  } vcode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'b00,
    SEQ_DECIDE = 2'b01,
    SEQ_ACTIVE = 2'b10
  } seq_e;

  localparam int unsigned MAX_RATIO = 8;

  // divider code to division ratio; the order follows the four pin levels
  function automatic logic [3:0] ratio_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd4;
      2'b01:   return 4'd1;
      2'b10:   return 4'd8;
      default: return 4'd2;
    endcase
  endfunction

  // final voltage from the level seen at the command edge and the window outcome
  function automatic vcode_e pick_voltage(input logic high_at_edge, input logic low_volt_hit);
    if (low_volt_hit)      return VC_1V8;
    else if (high_at_edge) return VC_5V0;
    else                   return VC_3V0;
  endfunction

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/sc_presence_filter.sv
module sc_presence_filter #(
  parameter int unsigned DEB_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic present
);

  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);

  logic [CW-1:0] stable_cnt;
  logic          held;
  logic          accept_evt;

  assign accept_evt = raw && !held && (stable_cnt == CW'(DEB_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_cnt <= '0;
      held       <= 1'b0;
    end else if (!raw) begin
      stable_cnt <= '0;
      held       <= 1'b0;
    end else if (stable_cnt == CW'(DEB_CYCLES)) begin
      held       <= 1'b1;
    end else begin
      stable_cnt <= stable_cnt + CW'(1);
    end
  end

  // removal bypasses the filter
  assign present = held & raw;

  // R1
  accept_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(stable_cnt) == CW'(DEB_CYCLES));

  // R1
  accept_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> held || !raw);

endmodule

// File: rtl/sc_power_seq.sv
module sc_power_seq
  import sc_sup_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 50
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_n_s,
  input  logic   vsel_s,
  input  logic   present,
  output logic   supply_en,
  output vcode_e vcode,
  output logic   cmd_edge
);

  localparam int unsigned CW = $clog2(WIN_CYCLES + 2);
  localparam logic [CW-1:0] WIN_V = CW'(WIN_CYCLES);
  localparam logic [CW-1:0] SAT_V = CW'(WIN_CYCLES + 1);

  seq_e          state;
  logic          cmd_prev, vsel_prev;
  logic [CW-1:0] since_fall, win_cnt;
  logic          high_at_edge, hit;
  vcode_e        code_q;

  logic cmd_fall, cmd_rise, vsel_fall, early_hit, late_hit, window_end;

  assign cmd_fall   = cmd_prev & ~cmd_n_s;
  assign cmd_rise   = ~cmd_prev & cmd_n_s;
  assign vsel_fall  = vsel_prev & ~vsel_s;
  assign early_hit  = vsel_fall | (~vsel_s & (since_fall < WIN_V));
  assign late_hit   = vsel_fall & high_at_edge;
  assign window_end = (state == SEQ_DECIDE) && (win_cnt == WIN_V);
  assign cmd_edge   = cmd_fall | cmd_rise;

  // cycles since the last voltage-select fall, saturating just past the window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_prev   <= 1'b1;
      vsel_prev  <= 1'b1;
      since_fall <= SAT_V;
    end else begin
      cmd_prev  <= cmd_n_s;
      vsel_prev <= vsel_s;
      if (vsel_fall)                since_fall <= '0;
      else if (since_fall != SAT_V) since_fall <= since_fall + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SEQ_IDLE;
      win_cnt      <= '0;
      high_at_edge <= 1'b0;
      hit          <= 1'b0;
      code_q       <= VC_OFF;
    end else begin
      case (state)
        SEQ_IDLE: begin
          code_q <= VC_OFF;
          if (cmd_fall && present) begin
            state        <= SEQ_DECIDE;
            win_cnt      <= CW'(1);
            high_at_edge <= vsel_s;
            hit          <= early_hit;
          end
        end
        SEQ_DECIDE: begin
          if (cmd_n_s || !present) begin
            state <= SEQ_IDLE;
          end else begin
            if (late_hit) hit <= 1'b1;
            if (window_end) begin
              state  <= SEQ_ACTIVE;
              code_q <= pick_voltage(high_at_edge, hit | late_hit);
            end else begin
              win_cnt <= win_cnt + CW'(1);
            end
          end
        end
        SEQ_ACTIVE: begin
          if (cmd_n_s || !present) begin
            state  <= SEQ_IDLE;
            code_q <= VC_OFF;
          end
        end
        default: begin
          state  <= SEQ_IDLE;
          code_q <= VC_OFF;
        end
      endcase
    end
  end

  assign supply_en = (state == SEQ_ACTIVE);
  assign vcode     = code_q;

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_en && $past(supply_en) |-> $stable(code_q));

  // R4
  code_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_en == (code_q != VC_OFF));

  // R12
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_n_s |=> !supply_en);

  // R6
  window_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_en) |-> $past(window_end));

endmodule

// File: rtl/sc_clk_divider.sv
module sc_clk_divider
  import sc_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);

  localparam int unsigned CW = $clog2(MAX_RATIO);

  logic [1:0]    ratio_q;
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (4'(cnt) == ratio_of(ratio_q) - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= 2'b00;
      cnt     <= '0;
    end else if (!run) begin
      ratio_q <= sel;
      cnt     <= '0;
    end else if (wrap) begin
      cnt     <= '0;
    end else begin
      cnt     <= cnt + CW'(1);
    end
  end

  assign tick = run & (cnt == '0);

  // R9
  ratio_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> $stable(ratio_q));

  // R8
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && $past(tick) |-> ratio_q == 2'b01);

endmodule

// File: rtl/sc_supervisor.sv
module sc_supervisor
  import sc_sup_pkg::*;
#(
  parameter int unsigned DEB_CYCLES  = 625000,
  parameter int unsigned WIN_CYCLES  = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       card_det,
  input  logic       pwr_cmd_n,
  input  logic       vsel,
  input  logic [1:0] div_sel,
  input  logic       fault,
  output logic       supply_en,
  output logic [1:0] vsel_code,
  output logic       card_clk_en,
  output logic       irq_n
);

  logic   card_s, cmd_n_s, vsel_s, fault_s;
  logic   present, cmd_edge;
  vcode_e vcode;
  logic   pres_prev, chg_flag, pres_change;

  sc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({card_det, pwr_cmd_n, vsel, fault}),
    .q     ({card_s, cmd_n_s, vsel_s, fault_s})
  );

  sc_presence_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw     (card_s),
    .present (present)
  );

  sc_power_seq #(.WIN_CYCLES(WIN_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_n_s   (cmd_n_s),
    .vsel_s    (vsel_s),
    .present   (present),
    .supply_en (supply_en),
    .vcode     (vcode),
    .cmd_edge  (cmd_edge)
  );

  sc_clk_divider u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (supply_en),
    .sel   (div_sel),
    .tick  (card_clk_en)
  );

  assign vsel_code   = vcode;
  assign pres_change = present ^ pres_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_prev <= 1'b0;
      chg_flag  <= 1'b0;
    end else begin
      pres_prev <= present;
      if (pres_change)   chg_flag <= 1'b1;
      else if (cmd_edge) chg_flag <= 1'b0;
    end
  end

  assign irq_n = ~(chg_flag | fault_s);

  // R11
  fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_s |-> !irq_n);

  // R10
  change_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pres_change |=> !irq_n);

  // R2
  removal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !card_s |=> !supply_en && !card_clk_en);

  // R3
  needs_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_en) |-> $past(present));

endmodule

// File: tb/test_sc_supervisor.sv
module test_sc_supervisor;

  localparam int DEB = 40;
  localparam int WIN = 6;
  localparam logic [1:0] E_OFF = 2'b00, E_3V = 2'b01, E_5V = 2'b10, E_18 = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n, card_det, pwr_cmd_n, vsel, fault;
  logic [1:0] div_sel;
  logic       supply_en, card_clk_en, irq_n;
  logic [1:0] vsel_code;

  int checks = 0;
  int fails  = 0;
  logic [1:0] exp_q[$];

  always #4 clk = ~clk;

  sc_supervisor #(.DEB_CYCLES(DEB), .WIN_CYCLES(WIN), .SYNC_STAGES(2)) i_sc_supervisor (
    .clk(clk), .rst_n(rst_n), .card_det(card_det), .pwr_cmd_n(pwr_cmd_n), .vsel(vsel),
    .div_sel(div_sel), .fault(fault), .supply_en(supply_en), .vsel_code(vsel_code),
    .card_clk_en(card_clk_en), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (card_clk_en) c++;
    end
  endtask

  // monitor: each rising supply enable is matched with the next expected code
  initial begin
    forever begin
      @(posedge supply_en);
      @(negedge clk);
      if (exp_q.size() == 0) chk("R3 unexpected activation", 1, 0);
      else chk("R4 R5 R6 latched voltage code", vsel_code, exp_q.pop_front());
    end
  end

  // driver: mode 0 level, mode 1 vsel falls d cycles before command, mode 2 d cycles after
  task automatic activate(input int mode, input int d, input logic [1:0] exp);
    int t;
    exp_q.push_back(exp);
    case (mode)
      0: begin vsel = (exp == E_5V); cyc(WIN + 4); pwr_cmd_n = 1'b0; end
      1: begin vsel = 1'b1; cyc(WIN + 4); vsel = 1'b0; cyc(d); pwr_cmd_n = 1'b0; end
      default: begin vsel = 1'b1; cyc(WIN + 4); pwr_cmd_n = 1'b0; cyc(d); vsel = 1'b0; end
    endcase
    t = 0;
    while (!supply_en && t < WIN + 20) begin cyc(1); t++; end
    chk("R3 session started", supply_en, 1);
    cyc(2);
  endtask

  task automatic release_cmd();
    pwr_cmd_n = 1'b1;
    cyc(3);
    chk("R12 supply off after release", supply_en, 0);
    chk("R12 strobe off after release", card_clk_en, 0);
    chk("R4 code off when unpowered", vsel_code, E_OFF);
    vsel = 1'b1;
    cyc(WIN + 4);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int c;
    rst_n = 1'b0; card_det = 1'b0; pwr_cmd_n = 1'b1; vsel = 1'b1; fault = 1'b0; div_sel = 2'b00;
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    chk("R4 reset code", vsel_code, E_OFF);
    chk("R3 reset supply", supply_en, 0);
    chk("R8 reset strobe", card_clk_en, 0);
    chk("R10 reset irq", irq_n, 1);

    // R1: short bounce is ignored, a held insertion is accepted
    card_det = 1'b1; cyc(DEB - 5); card_det = 1'b0; cyc(10);
    chk("R1 short pulse ignored", irq_n, 1);
    card_det = 1'b1; cyc(DEB - 3);
    chk("R1 not accepted early", irq_n, 1);
    cyc(11);
    chk("R1 accepted after hold", irq_n, 0);
    cyc(20);
    chk("R10 irq sticky", irq_n, 0);

    // R4 5V, R10 clear on command edge, R8 /4, R7, R9
    activate(0, 0, E_5V);
    chk("R10 cleared by command edge", irq_n, 1);
    count_ticks(40, c); chk("R8 divide by 4", c, 10);
    vsel = 1'b0; cyc(5); vsel = 1'b1; cyc(5); vsel = 1'b0; cyc(3);
    chk("R7 vsel ignored while powered", vsel_code, E_5V);
    vsel = 1'b1;
    div_sel = 2'b10; cyc(2);
    count_ticks(40, c); chk("R9 ratio frozen during session", c, 10);
    release_cmd();

    // R11 fault
    fault = 1'b1; cyc(4); chk("R11 fault drives irq", irq_n, 0);
    fault = 1'b0; cyc(4); chk("R11 irq released with fault", irq_n, 1);

    // R4 3V with /8
    activate(0, 0, E_3V);
    count_ticks(40, c); chk("R8 divide by 8", c, 5);
    release_cmd();

    // R5 early boundaries
    div_sel = 2'b01;
    activate(1, WIN, E_18);
    count_ticks(40, c); chk("R8 divide by 1", c, 40);
    release_cmd();
    div_sel = 2'b11;
    activate(1, WIN + 1, E_3V);
    count_ticks(40, c); chk("R8 divide by 2", c, 20);
    release_cmd();
    activate(1, 0, E_18);
    release_cmd();

    // R6 late boundaries
    activate(2, WIN, E_18);
    release_cmd();
    activate(2, WIN + 1, E_5V);
    release_cmd();
    activate(2, 1, E_18);
    release_cmd();

    // R2 removal mid-session
    activate(0, 0, E_5V);
    card_det = 1'b0; cyc(3);
    chk("R2 supply dropped on removal", supply_en, 0);
    chk("R2 strobe dropped on removal", card_clk_en, 0);
    cyc(1);
    chk("R10 removal raises irq", irq_n, 0);

    // R3 command without card
    pwr_cmd_n = 1'b1; cyc(4);
    pwr_cmd_n = 1'b0; cyc(WIN + 15);
    chk("R3 no card no supply", supply_en, 0);
    pwr_cmd_n = 1'b1; cyc(4);
    chk("R3 scoreboard drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule